// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This unit is the status and interrupt half of a serial peripheral controller. It keeps two byte queues, one carrying bytes from the processor bus to a serial shift engine and one carrying received bytes back. Software moves data through two port registers. A full-word access moves four bytes in one step, with the first byte of the stream in bits 31:24. A byte-wide access moves one byte in bits 7:0, which is how a short tail is drained.

The unit turns queue occupancy into two level events, "receive has data" and "transmit has room". Each event is compared against a programmable threshold. It also records a sticky overflow event when a transmit write finds no room. Events are held in a write-one-to-clear register. A mask register selects which of them drive the single interrupt line. The engine side is a plain byte stream. The engine pushes received bytes and marks the final byte of a transaction, and it pops bytes to transmit. The shifting itself belongs to the engine.

Register offsets on `bus_addr`: 0 configuration, 1 events, 2 mask, 3 transmit port, 4 receive port.

Top module: `spi_evt_unit`

## Requirements
- R1: After reset every event bit and the mask are zero, both counts are zero, `irq` is low, and the configuration word reads 0x0000_0403 (transmit threshold 4 in bits 13:8, receive threshold 3 in bits 5:0).
- R2: The event word carries the receive byte count in bits 29:24 and the transmit byte count in bits 21:16. Each count reflects the queue one cycle after the access that changed it.
- R3: A full-word write to the transmit port queues four bytes, and the engine receives bits 31:24 first and bits 7:0 last. A byte-wide write queues only bits 7:0.
- R4: A full-word read of the receive port removes four bytes and returns the oldest in bits 31:24. A byte-wide read removes one byte and returns it in bits 7:0 with the upper bits zero.
- R5: A read of the receive port that asks for more bytes than are queued returns zero and removes nothing.
- R6: A transmit write that does not fit in the free space is dropped whole and sets the overflow event (bit 10). That bit stays set until software writes a one to it.
- R7: The receive-data event (bit 9) is set when the receive count is greater than the receive threshold.
- R8: The receive-data event is also set while bytes remain after the engine delivered a byte flagged as the transaction's last. The flag is forgotten once the queue empties.
- R9: The transmit-room event (bit 8) is set when the transmit count is below the transmit threshold.
- R10: Writing a one to an event bit clears it and writing a zero leaves it alone. A level event whose condition still holds stays set.
- R11: The mask uses the event bit positions 10:8. `irq` is high exactly while some event bit and its mask bit are both set.
- R12: The receive queue holds 32 bytes. `eng_rx_full` is high at 32, and a further engine push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register offset |
| bus_byte | input | 1 | 1 byte-wide port access, 0 full word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_last | input | 1 | Byte is the last of the transaction |
| eng_rx_full | output | 1 | Receive queue full |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_data | output | 8 | Head transmit byte |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| irq | output | 1 | Level interrupt |

## Verification
The bench works the threshold edges. It checks that a receive count equal to the threshold raises no event and that one byte more does. Transmit room is tested the same way after the threshold is moved. A design that used the wrong comparison would raise interrupts one byte early or late. Short reads on a nearly empty queue and writes to a full transmit queue are checked for zero data, unchanged counts and a sticky overflow; a wrong design would corrupt the stream or lose the overflow report. The last-byte tail flag is shown to raise the event below threshold and to be forgotten once the queue drains. Clearing an event whose condition still holds is shown not to drop it.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;

  localparam int CNT_W = 6;
  localparam int THR_W = 6;

  typedef enum logic [2:0] {
    A_CFG  = 3'd0,
    A_EVT  = 3'd1,
    A_MASK = 3'd2,
    A_TXP  = 3'd3,
    A_RXP  = 3'd4
  } reg_addr_e;

  // event flags occupy bits 10:8 of the event and mask words
  localparam int FLAG_LSB = 8;

  function automatic logic rx_ne_fn(input logic [CNT_W-1:0] cnt,
                                    input logic [THR_W-1:0] thr,
                                    input logic tail);
    return (cnt > thr) || (tail && (cnt != '0));
  endfunction

  function automatic logic tx_nf_fn(input logic [CNT_W-1:0] cnt,
                                    input logic [THR_W-1:0] thr);
    return cnt < thr;
  endfunction

  function automatic logic [31:0] evt_word_fn(input logic [CNT_W-1:0] rxc,
                                              input logic [CNT_W-1:0] txc,
                                              input logic [2:0] flags);
    logic [31:0] w;
    w = '0;
    w[24 +: CNT_W] = rxc;
    w[16 +: CNT_W] = txc;
    w[FLAG_LSB +: 3] = flags;
    return w;
  endfunction

  function automatic logic [31:0] cfg_word_fn(input logic [THR_W-1:0] tx_thr,
                                              input logic [THR_W-1:0] rx_thr);
    logic [31:0] w;
    w = '0;
    w[8 +: THR_W] = tx_thr;
    w[0 +: THR_W] = rx_thr;
    return w;
  endfunction

endpackage

// File: rtl/spi_evt_fifo.sv
module spi_evt_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      push_n,
  input  logic [LANES*8-1:0] push_data,
  input  logic [NW-1:0]      pop_n,
  output logic [LANES*8-1:0] head,
  output logic [CW-1:0]      count,
  output logic [CW-1:0]      free
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_n);
      rd_ptr <= rd_ptr + PW'(pop_n);
      cnt_q  <= cnt_q + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(push_n)) mem[wr_ptr + PW'(i)] <= push_data[i*8 +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_head
    assign head[g*8 +: 8] = mem[rd_ptr + PW'(g)];
  end

  assign count = cnt_q;
  assign free  = CW'(DEPTH) - cnt_q;

endmodule

// File: rtl/spi_evt_ctrl.sv
module spi_evt_ctrl
  import spi_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             mask_we,
  input  logic             evt_we,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic             rx_last_acc,
  input  logic             tx_drop,
  output logic [31:0]      cfg_word,
  output logic [2:0]       mask_q,
  output logic [2:0]       evt_q,
  output logic [2:0]       evt_clr,
  output logic             ne_cond,
  output logic             nf_cond,
  output logic             irq
);

  logic [THR_W-1:0] rx_thr_q;
  logic [THR_W-1:0] tx_thr_q;
  logic             tail_q;
  logic [2:0]       evt_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr_q <= THR_W'(3);
      tx_thr_q <= THR_W'(4);
    end else if (cfg_we) begin
      rx_thr_q <= wdata[0 +: THR_W];
      tx_thr_q <= wdata[8 +: THR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mask_q <= '0;
    else if (mask_we)          mask_q <= wdata[FLAG_LSB +: 3];
  end

  // remembers that the transaction's final byte is sitting in the queue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tail_q <= 1'b0;
    else if (rx_last_acc)      tail_q <= 1'b1;
    else if (rx_cnt == '0)     tail_q <= 1'b0;
  end

  assign ne_cond = rx_ne_fn(rx_cnt, rx_thr_q, tail_q);
  assign nf_cond = tx_nf_fn(tx_cnt, tx_thr_q);
  assign evt_set = {tx_drop, ne_cond, nf_cond};
  assign evt_clr = evt_we ? wdata[FLAG_LSB +: 3] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~evt_clr) | evt_set;
  end

  assign irq      = |(evt_q & mask_q);
  assign cfg_word = cfg_word_fn(tx_thr_q, rx_thr_q);

endmodule

// File: rtl/spi_evt_unit.sv
module spi_evt_unit
  import spi_evt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic        bus_byte,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_rx_last,
  output logic        eng_rx_full,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  output logic        eng_tx_avail,
  output logic        irq
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int NW = 3;

  // bus decode
  logic wr_acc, rd_acc;
  logic cfg_we, mask_we, evt_we, txp_we, rxp_re;
  assign wr_acc  = bus_cs &  bus_we;
  assign rd_acc  = bus_cs & ~bus_we;
  assign cfg_we  = wr_acc && (bus_addr == A_CFG);
  assign evt_we  = wr_acc && (bus_addr == A_EVT);
  assign mask_we = wr_acc && (bus_addr == A_MASK);
  assign txp_we  = wr_acc && (bus_addr == A_TXP);
  assign rxp_re  = rd_acc && (bus_addr == A_RXP);

  logic [NW-1:0] acc_bytes;
  assign acc_bytes = bus_byte ? NW'(1) : NW'(4);

  // receive side
  logic [NW-1:0] rx_push_n, rx_pop_n;
  logic [31:0]   rx_head;
  logic [CW-1:0] rx_cnt, rx_free;
  logic          rx_rd_ok, rx_rd_short, rx_last_acc;

  assign rx_push_n   = (eng_rx_push && rx_cnt != CW'(DEPTH)) ? NW'(1) : NW'(0);
  assign rx_last_acc = eng_rx_last && (rx_push_n != '0);
  assign rx_rd_ok    = rxp_re && (rx_cnt >= CW'(acc_bytes));
  assign rx_rd_short = rxp_re && !rx_rd_ok;
  assign rx_pop_n    = rx_rd_ok ? acc_bytes : NW'(0);
  assign eng_rx_full = (rx_cnt == CW'(DEPTH));

  spi_evt_fifo #(.DEPTH(DEPTH), .LANES(4)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (rx_push_n),
    .push_data({24'h0, eng_rx_data}),
    .pop_n    (rx_pop_n),
    .head     (rx_head),
    .count    (rx_cnt),
    .free     (rx_free)
  );

  logic [31:0] rx_rd_data;
  always_comb begin
    rx_rd_data = '0;
    if (rx_rd_ok) begin
      if (bus_byte) rx_rd_data = {24'h0, rx_head[7:0]};
      else          rx_rd_data = {rx_head[7:0], rx_head[15:8], rx_head[23:16], rx_head[31:24]};
    end
  end

  // transmit side
  logic [NW-1:0] tx_push_n, tx_pop_n;
  logic [31:0]   tx_head, tx_lanes;
  logic [CW-1:0] tx_cnt, tx_free;
  logic          tx_fits, tx_drop;

  assign tx_fits   = tx_free >= CW'(acc_bytes);
  assign tx_drop   = txp_we && !tx_fits;
  assign tx_push_n = (txp_we && tx_fits) ? acc_bytes : NW'(0);
  assign tx_lanes  = bus_byte ? {24'h0, bus_wdata[7:0]}
                              : {bus_wdata[7:0], bus_wdata[15:8], bus_wdata[23:16], bus_wdata[31:24]};
  assign eng_tx_avail = (tx_cnt != '0);
  assign tx_pop_n  = (eng_tx_pop && eng_tx_avail) ? NW'(1) : NW'(0);
  assign eng_tx_data = tx_head[7:0];

  spi_evt_fifo #(.DEPTH(DEPTH), .LANES(4)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_n   (tx_push_n),
    .push_data(tx_lanes),
    .pop_n    (tx_pop_n),
    .head     (tx_head),
    .count    (tx_cnt),
    .free     (tx_free)
  );

  // events, mask, thresholds
  logic [31:0] cfg_word;
  logic [2:0]  mask_q, evt_q, evt_clr;
  logic        ne_cond, nf_cond;
  logic [CNT_W-1:0] rx_cnt_w, tx_cnt_w;
  assign rx_cnt_w = CNT_W'(rx_cnt);
  assign tx_cnt_w = CNT_W'(tx_cnt);

  spi_evt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .mask_we    (mask_we),
    .evt_we     (evt_we),
    .wdata      (bus_wdata),
    .rx_cnt     (rx_cnt_w),
    .tx_cnt     (tx_cnt_w),
    .rx_last_acc(rx_last_acc),
    .tx_drop    (tx_drop),
    .cfg_word   (cfg_word),
    .mask_q     (mask_q),
    .evt_q      (evt_q),
    .evt_clr    (evt_clr),
    .ne_cond    (ne_cond),
    .nf_cond    (nf_cond),
    .irq        (irq)
  );

  always_comb begin
    unique case (bus_addr)
      A_CFG:   bus_rdata = cfg_word;
      A_EVT:   bus_rdata = evt_word_fn(rx_cnt_w, tx_cnt_w, evt_q);
      A_MASK:  bus_rdata = {21'h0, mask_q, 8'h0};
      A_RXP:   bus_rdata = rx_rd_data;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_evt_chk.sv
module spi_evt_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [2:0]    evt_q,
  input logic [2:0]    mask_q,
  input logic [2:0]    evt_clr,
  input logic          mask_we,
  input logic          ne_cond,
  input logic          tx_drop,
  input logic          rx_rd_short,
  input logic [2:0]    rx_push_n,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic [2:0]    tx_push_n,
  input logic [2:0]    tx_pop_n
);

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 3'b000) |-> !irq);

  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_q & mask_q)) && (evt_clr == 3'b000) && !mask_we) |=> irq);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> evt_q[2]);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[2] && !evt_clr[2]) |=> evt_q[2]);

  // R10
  ne_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr[1] && !ne_cond) |=> !evt_q[1]);

  // R5
  rx_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_short && rx_push_n == 3'd0) |=> $stable(rx_cnt));

  // R12
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  // R3
  tx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_n != 3'd0 || tx_pop_n != 3'd0) |=>
      tx_cnt == $past(tx_cnt) + CW'($past(tx_push_n)) - CW'($past(tx_pop_n)));

endmodule

bind spi_evt_unit spi_evt_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .evt_q      (evt_q),
  .mask_q     (mask_q),
  .evt_clr    (evt_clr),
  .mask_we    (mask_we),
  .ne_cond    (ne_cond),
  .tx_drop    (tx_drop),
  .rx_rd_short(rx_rd_short),
  .rx_push_n  (rx_push_n),
  .rx_cnt     (rx_cnt),
  .tx_cnt     (tx_cnt),
  .tx_push_n  (tx_push_n),
  .tx_pop_n   (tx_pop_n)
);

// File: tb/spi_evt_unit_test.sv
module spi_evt_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_we = 1'b0, bus_byte = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_rx_push = 1'b0, eng_rx_last = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_rx_full;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_tx_data;
  logic        eng_tx_avail;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  localparam logic [2:0] O_CFG = 3'd0, O_EVT = 3'd1, O_MASK = 3'd2, O_TXP = 3'd3, O_RXP = 3'd4;

  always #10 clk = ~clk;

  spi_evt_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_last(eng_rx_last),
    .eng_rx_full(eng_rx_full), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_tx_avail(eng_tx_avail), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic bw);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = bw;
    @(posedge clk); #1;
    bus_cs = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic bw, output logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a; bus_byte = bw;
    #5 d = bus_rdata;
    @(posedge clk); #1;
    bus_cs = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic last);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = b; eng_rx_last = last;
    @(posedge clk); #1;
    eng_rx_push = 1'b0; eng_rx_last = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk);
    eng_tx_pop = 1'b1;
    #5 b = eng_tx_data;
    @(posedge clk); #1;
    eng_tx_pop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [5:0] rxc(input logic [31:0] w); return w[29:24]; endfunction
  function automatic logic [5:0] txc(input logic [31:0] w); return w[21:16]; endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(O_EVT, 1'b0, d);  chk("R1 event word at reset", d, 32'h0);
    rd(O_CFG, 1'b0, d);  chk("R1 config at reset", d, 32'h0000_0403);
    rd(O_MASK, 1'b0, d); chk("R1 mask at reset", d, 32'h0);
    chk("R1 irq at reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_tx_order();
    logic [31:0] d;
    logic [7:0] b;
    wr(O_TXP, 32'hA1B2C3D4, 1'b0);
    rd(O_EVT, 1'b0, d); chk("R2 tx count after word write", {26'h0, txc(d)}, 32'd4);
    pop(b); chk("R3 first byte 31:24", {24'h0, b}, 32'hA1);
    pop(b); chk("R3 second byte", {24'h0, b}, 32'hB2);
    pop(b); chk("R3 third byte", {24'h0, b}, 32'hC3);
    pop(b); chk("R3 last byte 7:0", {24'h0, b}, 32'hD4);
    wr(O_TXP, 32'h7766_5555, 1'b1);
    rd(O_EVT, 1'b0, d); chk("R3 byte write queues one", {26'h0, txc(d)}, 32'd1);
    pop(b); chk("R3 byte write data", {24'h0, b}, 32'h55);
    chk("R3 queue empty after pops", {31'h0, eng_tx_avail}, 32'h0);
  endtask

  task automatic t_rx_read();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) push(8'h11 + 8'(i), 1'b0);
    rd(O_EVT, 1'b0, d); chk("R2 rx count field", {26'h0, rxc(d)}, 32'd5);
    rd(O_RXP, 1'b0, d); chk("R4 word read order", d, 32'h11121314);
    rd(O_EVT, 1'b0, d); chk("R4 word read removes four", {26'h0, rxc(d)}, 32'd1);
    rd(O_RXP, 1'b1, d); chk("R4 byte read", d, 32'h15);
    rd(O_EVT, 1'b0, d); chk("R4 byte read removes one", {26'h0, rxc(d)}, 32'd0);
  endtask

  task automatic t_rx_short();
    logic [31:0] d;
    push(8'h21, 1'b0); push(8'h22, 1'b0);
    rd(O_RXP, 1'b0, d); chk("R5 short word read data", d, 32'h0);
    rd(O_EVT, 1'b0, d); chk("R5 short word read keeps count", {26'h0, rxc(d)}, 32'd2);
    rd(O_RXP, 1'b1, d); chk("R5 tail byte 1", d, 32'h21);
    rd(O_RXP, 1'b1, d); chk("R5 tail byte 2", d, 32'h22);
    rd(O_RXP, 1'b1, d); chk("R5 empty byte read", d, 32'h0);
    rd(O_EVT, 1'b0, d); chk("R5 empty read keeps count", {26'h0, rxc(d)}, 32'd0);
  endtask

  task automatic t_ne_thr();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) push(8'h30 + 8'(i), 1'b0);
    idle(2); wr(O_EVT, 32'h0000_0200, 1'b0); idle(2);
    rd(O_EVT, 1'b0, d); chk("R7 count equal to threshold no event", {31'h0, d[9]}, 32'h0);
    push(8'h33, 1'b0); idle(2);
    rd(O_EVT, 1'b0, d); chk("R7 count above threshold", {31'h0, d[9]}, 32'h1);
    wr(O_MASK, 32'h0000_0200, 1'b0);
    chk("R11 irq on masked-in event", {31'h0, irq}, 32'h1);
    rd(O_RXP, 1'b0, d); chk("R7 drain word", d, 32'h30313233);
    idle(1); wr(O_EVT, 32'h0000_0200, 1'b0); idle(2);
    rd(O_EVT, 1'b0, d); chk("R10 cleared once condition gone", {31'h0, d[9]}, 32'h0);
    chk("R11 irq drops after clear", {31'h0, irq}, 32'h0);
    wr(O_MASK, 32'h0, 1'b0);
  endtask

  task automatic t_tail();
    logic [31:0] d;
    push(8'h41, 1'b0); push(8'h42, 1'b1); idle(2);
    rd(O_EVT, 1'b0, d); chk("R8 last byte raises event below threshold", {31'h0, d[9]}, 32'h1);
    rd(O_RXP, 1'b1, d); rd(O_RXP, 1'b1, d);
    chk("R8 tail data", d, 32'h42);
    idle(2); wr(O_EVT, 32'h0000_0200, 1'b0);
    push(8'h43, 1'b0); idle(2);
    rd(O_EVT, 1'b0, d); chk("R8 tail flag forgotten after drain", {31'h0, d[9]}, 32'h0);
    rd(O_RXP, 1'b1, d);
    idle(1); wr(O_EVT, 32'h0000_0200, 1'b0);
  endtask

  task automatic t_nf();
    logic [31:0] d;
    logic [7:0] b;
    wr(O_CFG, 32'h0000_0203, 1'b0);
    rd(O_CFG, 1'b0, d); chk("R9 threshold written", d, 32'h0000_0203);
    wr(O_TXP, 32'h1, 1'b1); wr(O_TXP, 32'h2, 1'b1);
    idle(2); wr(O_EVT, 32'h0000_0100, 1'b0); idle(2);
    rd(O_EVT, 1'b0, d); chk("R9 count equal to threshold no room event", {31'h0, d[8]}, 32'h0);
    pop(b); idle(2);
    rd(O_EVT, 1'b0, d); chk("R9 count below threshold", {31'h0, d[8]}, 32'h1);
    pop(b); chk("R9 second byte", {24'h0, b}, 32'h02);
    wr(O_CFG, 32'h0000_0403, 1'b0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    idle(2);
    wr(O_EVT, 32'h0000_0100, 1'b0);
    rd(O_EVT, 1'b0, d); chk("R10 held condition keeps bit", {31'h0, d[8]}, 32'h1);
  endtask

  task automatic t_ovf();
    logic [31:0] d;
    logic [7:0] b;
    for (int k = 0; k < 8; k++)
      wr(O_TXP, {8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)}, 1'b0);
    rd(O_EVT, 1'b0, d); chk("R6 no overflow while fitting", {31'h0, d[10]}, 32'h0);
    wr(O_TXP, 32'hEEEEEEEE, 1'b0);
    wr(O_TXP, 32'hEE, 1'b1);
    idle(1);
    rd(O_EVT, 1'b0, d);
    chk("R6 overflow set", {31'h0, d[10]}, 32'h1);
    chk("R6 dropped write leaves count", {26'h0, txc(d)}, 32'd32);
    wr(O_EVT, 32'h0, 1'b0); idle(3);
    rd(O_EVT, 1'b0, d); chk("R10 writing zero keeps overflow", {31'h0, d[10]}, 32'h1);
    wr(O_EVT, 32'h0000_0400, 1'b0);
    rd(O_EVT, 1'b0, d); chk("R6 overflow cleared by one", {31'h0, d[10]}, 32'h0);
    begin
      int bad = 0;
      for (int i = 0; i < 32; i++) begin
        pop(b);
        if (b != 8'(i)) bad++;
      end
      chk("R6 stream intact after dropped write", bad, 0);
    end
    chk("R6 nothing extra queued", {31'h0, eng_tx_avail}, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    idle(2);
    chk("R11 mask zero irq low", {31'h0, irq}, 32'h0);
    wr(O_MASK, 32'h0000_0100, 1'b0);
    rd(O_MASK, 1'b0, d); chk("R11 mask readback", d, 32'h0000_0100);
    chk("R11 room event drives irq", {31'h0, irq}, 32'h1);
    wr(O_MASK, 32'h0000_0400, 1'b0);
    chk("R11 irq low with other bit masked", {31'h0, irq}, 32'h0);
    wr(O_MASK, 32'h0, 1'b0);
  endtask

  task automatic t_rx_full();
    logic [31:0] d;
    for (int i = 0; i < 33; i++) push(8'h40 + 8'(i), 1'b0);
    chk("R12 full flag", {31'h0, eng_rx_full}, 32'h1);
    rd(O_EVT, 1'b0, d); chk("R12 count capped", {26'h0, rxc(d)}, 32'd32);
    for (int k = 0; k < 8; k++) rd(O_RXP, 1'b0, d);
    chk("R12 last word excludes dropped byte", d, 32'h5C5D5E5F);
    rd(O_EVT, 1'b0, d); chk("R12 empty after drain", {26'h0, rxc(d)}, 32'd0);
    idle(1); wr(O_EVT, 32'h0000_0700, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_tx_order();
    t_rx_read();
    t_rx_short();
    t_ne_thr();
    t_tail();
    t_nf();
    t_w1c();
    t_ovf();
    t_irq();
    t_rx_full();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule